// File: doc/BRIEF.md
# Address-Masked GPIO Port with Interrupt Detection

This block is an eight-pin general-purpose I/O port on a plain 32-bit register bus (address, write enable, write data, combinational read data). It stores the output value, the per-pin direction and a per-pin hand-over to peripheral control. The data window uses part of the address as a per-pin mask. Software can therefore drive or sample any subset of pins in one bus access, with no read-modify-write.

Each pin has its own interrupt detector. The detector watches for edges or levels, on one edge or both, with a selectable polarity. Raw status is kept separately from the enable mask. Latched edges are cleared by writing ones, and all enabled pins are folded into one registered interrupt line.

Top module: `gpio_mask_port`

## Requirements
- R1: After synchronous reset every register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is 0.
- R2: A write to an offset below 0x400 uses address bits [9:2] as a pin mask (bit n selects pin n). Selected output bits take the matching write-data bits and unselected output bits keep their value.
- R3: A read below 0x400 returns the synchronized pin inputs on the bits selected by address bits [9:2] and 0 on every other bit.
- R4: The direction register at 0x400 drives `pin_oe` for pins not handed to a peripheral (1 = output). The output register drives `pin_out` for those pins.
- R5: A bit of 1 in the peripheral-select register at 0x420 makes that pin take `pin_out` from `periph_out` and `pin_oe` from `periph_oe`.
- R6: When the sense bit (0x404) is 0 the pin is edge-detected. With the both-edges bit (0x408) at 0, event bit (0x40C) = 1 selects rising and 0 selects falling. A detected edge latches in raw status (read at 0x414) until it is cleared.
- R7: A both-edges bit of 1 latches on rising and on falling edges, whatever the event bit holds.
- R8: When the sense bit is 1, raw status follows the synchronized pin level every cycle. It is 1 when the level equals the event bit (1 = high, 0 = low) and it is never latched.
- R9: Masked status (read at 0x418) is raw status ANDed with the enable register at 0x410. Raw status is kept whether or not the pin is enabled.
- R10: Writing 1 to a bit of the clear register at 0x41C clears that pin's latched edge, and writing 0 leaves it alone. The register reads 0. A clear has no lasting effect on level-sensed pins.
- R11: `irq` is the OR of all masked status bits, delayed by one register.
- R12: The direction, sense, both-edges, event, enable and peripheral-select registers read back the value written, in bits [7:0]. They change only on a write to their own offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data, bits [7:0] used |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| periph_out | input | 8 | Output values from the peripheral side |
| periph_oe | input | 8 | Output enables from the peripheral side |
| irq | output | 1 | Registered interrupt request |

## Verification
A stale or wrongly latched raw bit shows up at the raw-status offset within about three cycles of the pin change, and on `irq` one cycle later. Because of this the bench reads status after every stimulus rather than only watching the interrupt line. A wrongly decoded mask shows up at once on `pin_out` or in the read data, so the mask patterns are chosen to separate low, high and empty nibbles. A level pin that latches would show up only after the pin returns to its idle level, so level checks always include that return.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PIN_W  = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int MASK_LSB = 2;
    localparam int MASK_MSB = MASK_LSB + PIN_W - 1;

    localparam logic [ADDR_W-1:0] OFS_DIR    = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_SENSE  = 12'h404;
    localparam logic [ADDR_W-1:0] OFS_BOTH   = 12'h408;
    localparam logic [ADDR_W-1:0] OFS_EVENT  = 12'h40C;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h418;
    localparam logic [ADDR_W-1:0] OFS_ICLR   = 12'h41C;
    localparam logic [ADDR_W-1:0] OFS_PSEL   = 12'h420;

    typedef logic [PIN_W-1:0] pins_t;

    typedef struct packed {
        pins_t dir;
        pins_t sense;
        pins_t both;
        pins_t polarity;
        pins_t ien;
        pins_t psel;
    } cfg_t;

    typedef enum logic [1:0] {
        DET_FALL  = 2'd0,
        DET_RISE  = 2'd1,
        DET_BOTH  = 2'd2,
        DET_LEVEL = 2'd3
    } det_mode_e;

    function automatic logic in_data_window(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:MASK_MSB+1] == '0;
    endfunction

    function automatic pins_t addr_mask(input logic [ADDR_W-1:0] a);
        return a[MASK_MSB:MASK_LSB];
    endfunction

    function automatic det_mode_e pin_mode(input logic sense, input logic both,
                                           input logic pol);
        if (sense)     return DET_LEVEL;
        else if (both) return DET_BOTH;
        else if (pol)  return DET_RISE;
        else           return DET_FALL;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t pin_async,
    output pins_t level,
    output pins_t rise,
    output pins_t fall
);
    pins_t meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~prev_q;
    assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  pins_t             wdata,
    output cfg_t              cfg,
    output pins_t             out_val,
    output pins_t             clr_pulse
);
    cfg_t  cfg_q;
    pins_t out_q;
    pins_t wmask;

    assign wmask = addr_mask(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            out_q <= '0;
        end else if (we) begin
            if (in_data_window(addr)) begin
                out_q <= (out_q & ~wmask) | (wdata & wmask);
            end else begin
                case (addr)
                    OFS_DIR:   cfg_q.dir      <= wdata;
                    OFS_SENSE: cfg_q.sense    <= wdata;
                    OFS_BOTH:  cfg_q.both     <= wdata;
                    OFS_EVENT: cfg_q.polarity <= wdata;
                    OFS_IEN:   cfg_q.ien      <= wdata;
                    OFS_PSEL:  cfg_q.psel     <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign clr_pulse = (we && addr == OFS_ICLR) ? wdata : '0;
    assign cfg       = cfg_q;
    assign out_val   = out_q;

    // R12: configuration moves only on a bus write
    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg_q));
    // R2: unselected output bits keep their value across a data write
    p_data_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (we && in_data_window(addr)) |=>
            ((out_q & ~$past(wmask)) == ($past(out_q) & ~$past(wmask))));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cfg_t  cfg,
    input  pins_t level,
    input  pins_t rise,
    input  pins_t fall,
    input  pins_t clr_pulse,
    output pins_t raw,
    output pins_t masked
);
    pins_t latch_q;

    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        det_mode_e mode;
        logic      hit;
        assign mode = pin_mode(cfg.sense[i], cfg.both[i], cfg.polarity[i]);

        always_comb begin
            case (mode)
                DET_RISE: hit = rise[i];
                DET_FALL: hit = fall[i];
                DET_BOTH: hit = rise[i] | fall[i];
                default:  hit = 1'b0;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst)                latch_q[i] <= 1'b0;
            else if (mode == DET_LEVEL) latch_q[i] <= 1'b0;
            else                    latch_q[i] <= hit | (latch_q[i] & ~clr_pulse[i]);
        end

        assign raw[i] = (mode == DET_LEVEL) ? (level[i] == cfg.polarity[i])
                                            : latch_q[i];

        // R6: a latched edge stays until a clear
        p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
            (latch_q[i] && !cfg.sense[i] && !clr_pulse[i]) |=> latch_q[i]);
        // R6: a selected rising edge is latched on the next cycle
        p_rise_sets_r6: assert property (@(posedge clk) disable iff (rst)
            (!cfg.sense[i] && (cfg.both[i] || cfg.polarity[i]) && rise[i]) |=> latch_q[i]);
        // R7: both-edge mode latches a falling edge regardless of polarity
        p_both_fall_r7: assert property (@(posedge clk) disable iff (rst)
            (!cfg.sense[i] && cfg.both[i] && fall[i]) |=> latch_q[i]);
        // R8: level-sensed pins never hold a latched edge
        p_level_nolatch_r8: assert property (@(posedge clk) disable iff (rst)
            (cfg.sense[i] && $past(cfg.sense[i])) |-> !latch_q[i]);
    end

    assign masked = raw & cfg.ien;
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    input  logic [PIN_W-1:0]  periph_out,
    input  logic [PIN_W-1:0]  periph_oe,
    output logic              irq
);
    cfg_t  cfg;
    pins_t out_val, clr_pulse, level, rise, fall, raw, masked;
    pins_t rd_pins;
    logic  irq_q;
    logic  unused_bits;

    assign unused_bits = ^bus_wdata[DATA_W-1:PIN_W];

    gpio_sync u_sync (
        .clk(clk), .rst(rst), .pin_async(pin_in),
        .level(level), .rise(rise), .fall(fall)
    );

    gpio_cfg_regs u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata[PIN_W-1:0]), .cfg(cfg), .out_val(out_val),
        .clr_pulse(clr_pulse)
    );

    gpio_irq_detect u_det (
        .clk(clk), .rst(rst), .cfg(cfg), .level(level), .rise(rise),
        .fall(fall), .clr_pulse(clr_pulse), .raw(raw), .masked(masked)
    );

    always_comb begin
        if (in_data_window(bus_addr)) begin
            rd_pins = level & addr_mask(bus_addr);
        end else begin
            case (bus_addr)
                OFS_DIR:    rd_pins = cfg.dir;
                OFS_SENSE:  rd_pins = cfg.sense;
                OFS_BOTH:   rd_pins = cfg.both;
                OFS_EVENT:  rd_pins = cfg.polarity;
                OFS_IEN:    rd_pins = cfg.ien;
                OFS_RAW:    rd_pins = raw;
                OFS_MASKED: rd_pins = masked;
                OFS_PSEL:   rd_pins = cfg.psel;
                default:    rd_pins = '0;
            endcase
        end
    end
    assign bus_rdata = {{(DATA_W-PIN_W){1'b0}}, rd_pins};

    for (genvar i = 0; i < PIN_W; i++) begin : g_pad
        assign pin_out[i] = cfg.psel[i] ? periph_out[i] : out_val[i];
        assign pin_oe[i]  = cfg.psel[i] ? periph_oe[i]  : cfg.dir[i];
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |masked;
    end
    assign irq = irq_q;

    // R11: any enabled pending pin raises irq one cycle later
    p_irq_rise_r11: assert property (@(posedge clk) disable iff (rst)
        (|masked) |=> irq);
    // R11: no enabled pending pin means irq drops one cycle later
    p_irq_fall_r11: assert property (@(posedge clk) disable iff (rst)
        !(|masked) |=> !irq);
endmodule

// File: tb/gpio_mask_port_bench.sv
module gpio_mask_port_bench;
    import gpio_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int K_RDATA = 0, K_PINOUT = 1, K_PINOE = 2, K_IRQ = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [PIN_W-1:0]  pin_in = '0;
    logic [PIN_W-1:0]  pin_out, pin_oe;
    logic [PIN_W-1:0]  periph_out = '0;
    logic [PIN_W-1:0]  periph_oe = '0;
    logic              irq;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t expq[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mask_port u_gpio_mask_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .periph_out(periph_out),
        .periph_oe(periph_oe), .irq(irq)
    );

    // monitor: compares queued expectations against the ports
    always @(negedge clk) begin
        while (expq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = expq.pop_front();
            case (it.kind)
                K_RDATA:  act = bus_rdata;
                K_PINOUT: act = {24'h0, pin_out};
                K_PINOE:  act = {24'h0, pin_oe};
                default:  act = {31'h0, irq};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic expect_port(input int kind, input logic [31:0] e, input string req);
        item_t it;
        it.kind = kind; it.exp = e; it.req = req;
        expq.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string req);
        @(posedge clk); #1;
        bus_addr = a;
        expect_port(K_RDATA, e, req);
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        #1;
    endtask

    task automatic drive_pins(input logic [7:0] v);
        @(posedge clk); #1;
        pin_in = v;
        settle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_port(K_PINOE, 32'h0, "R1");
        expect_port(K_PINOUT, 32'h0, "R1");
        expect_port(K_IRQ, 32'h0, "R1");
        rd(OFS_DIR, 32'h0, "R1");
        rd(OFS_IEN, 32'h0, "R1");

        // R4 / R12 direction
        wr(OFS_DIR, 32'hA5);
        expect_port(K_PINOE, 32'hA5, "R4");
        rd(OFS_DIR, 32'hA5, "R12");

        // R2 masked writes: mask 0x0F at addr 0x03C, mask 0xF0 at 0x3C0, empty mask
        wr(12'h03C, 32'hFF);
        expect_port(K_PINOUT, 32'h0F, "R2");
        wr(12'h3C0, 32'h50);
        expect_port(K_PINOUT, 32'h5F, "R2");
        wr(12'h000, 32'h00);
        expect_port(K_PINOUT, 32'h5F, "R2");

        // R3 masked reads
        drive_pins(8'h3C);
        rd(12'h3FC, 32'h3C, "R3");
        rd(12'h03C, 32'h0C, "R3");
        rd(12'h000, 32'h00, "R3");

        // R5 peripheral hand-over of upper nibble
        periph_out = 8'hAA; periph_oe = 8'h0F;
        wr(OFS_PSEL, 32'hF0);
        expect_port(K_PINOUT, 32'hAF, "R5");
        expect_port(K_PINOE, 32'h05, "R5");
        rd(OFS_PSEL, 32'hF0, "R12");
        wr(OFS_PSEL, 32'h00);
        expect_port(K_PINOUT, 32'h5F, "R5");

        // interrupts: clear leftovers, pin0 rising, pin1 falling
        drive_pins(8'h00);
        wr(OFS_ICLR, 32'hFF);
        rd(OFS_RAW, 32'h00, "R10");
        wr(OFS_EVENT, 32'h01);
        drive_pins(8'h01);
        rd(OFS_RAW, 32'h01, "R6");
        rd(OFS_MASKED, 32'h00, "R9");
        expect_port(K_IRQ, 32'h0, "R9");
        wr(OFS_IEN, 32'h03);
        settle();
        rd(OFS_MASKED, 32'h01, "R9");
        expect_port(K_IRQ, 32'h1, "R11");
        drive_pins(8'h03);
        rd(OFS_RAW, 32'h01, "R6");
        drive_pins(8'h01);
        rd(OFS_RAW, 32'h03, "R6");
        drive_pins(8'h00);
        rd(OFS_RAW, 32'h03, "R6");

        // R10 write-one clear
        wr(OFS_ICLR, 32'h02);
        rd(OFS_RAW, 32'h01, "R10");
        wr(OFS_ICLR, 32'h00);
        rd(OFS_RAW, 32'h01, "R10");
        rd(OFS_ICLR, 32'h00, "R10");
        wr(OFS_ICLR, 32'h01);
        settle();
        rd(OFS_RAW, 32'h00, "R10");
        expect_port(K_IRQ, 32'h0, "R11");

        // R7 both edges on pin2, polarity bit 0
        wr(OFS_BOTH, 32'h04);
        drive_pins(8'h04);
        rd(OFS_RAW, 32'h04, "R7");
        wr(OFS_ICLR, 32'h04);
        drive_pins(8'h00);
        rd(OFS_RAW, 32'h04, "R7");
        wr(OFS_ICLR, 32'h04);

        // R8 level sensing on pin3
        wr(OFS_SENSE, 32'h08);
        wr(OFS_EVENT, 32'h09);
        settle();
        rd(OFS_RAW, 32'h00, "R8");
        drive_pins(8'h08);
        rd(OFS_RAW, 32'h08, "R8");
        wr(OFS_IEN, 32'h08);
        settle();
        expect_port(K_IRQ, 32'h1, "R11");
        wr(OFS_ICLR, 32'h08);
        rd(OFS_RAW, 32'h08, "R10");
        drive_pins(8'h00);
        rd(OFS_RAW, 32'h00, "R8");
        expect_port(K_IRQ, 32'h0, "R8");
        wr(OFS_EVENT, 32'h01);
        settle();
        rd(OFS_RAW, 32'h08, "R8");
        rd(OFS_SENSE, 32'h08, "R12");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule